// File: doc/BRIEF.md
# Bank-Switched RAM Expansion Controller

This block manages a 16 KB RAM expansion card on an 8-bit microcomputer bus with a 16-bit address. The card has a 16-address control window in the I/O page. Any bus cycle to one of these addresses acts as a soft switch. From these cycles the controller keeps three pieces of state: the read source (card RAM or motherboard ROM), a write-enable state machine, and a bank select.

For every CPU cycle in the 0xD000–0xFFFF range, the controller drives exactly one of four chip-selects or none. These are bank A, bank B, upper RAM and motherboard ROM. It also forms the RAM address and a RAM write strobe. The two 4 KB banks share the 0xD000–0xDFFF window, while the 8 KB upper RAM always answers in 0xE000–0xFFFF. The RAM arrays sit outside the block. Reads of a switch address make the block drive 0x00 onto the data bus.

The write-enable state machine has three states:
- `WE_OFF` (writes discarded)
- `WE_HALF` (one arming read seen)
- `WE_ON` (writes reach RAM)

It has five transitions:
- *arm*: `WE_OFF`→`WE_HALF` on an arming switch read.
- *open*: `WE_HALF`→`WE_ON` on a second arming read.
- *hold*: `WE_ON`→`WE_ON` on any further arming read.
- *close*: any state→`WE_OFF` on a non-arming switch read.
- *clear*: any state→`WE_OFF` on any switch write.

Top module: `bankram_ctrl`

## Requirements
- R1: A bus cycle is a switch access only when bus_addr[15:4] equals 0xC08 plus the SLOT parameter. Accesses outside that window change no state and do not drive the data bus.
- R2: After reset, reads in 0xD000–0xFFFF go to ROM, the write state is `WE_ON`, and bank B is active.
- R3: On a switch read, address bit 3 sets the active bank: 0 selects bank A and 1 selects bank B.
- R4: On a switch read, address bits 1:0 of 0 select RAM reads and 2 selects ROM reads. Both values force the write state to `WE_OFF`.
- R5: On a switch read, address bits 1:0 of 1 select ROM reads and 3 selects RAM reads. Both values advance the write state one step, and it saturates at `WE_ON`. Two such reads in a row from `WE_OFF` open writes.
- R6: A write cycle to a switch address forces `WE_OFF` and leaves the read source and the bank unchanged.
- R7: A read in 0xD000–0xDFFF selects the active bank's chip-select when RAM reads are selected. A read in 0xE000–0xFFFF selects the upper-RAM chip-select in that case. Otherwise any read in 0xD000–0xFFFF selects ROM.
- R8: In `WE_ON`, a write in 0xD000–0xFFFF raises ram_we together with the active-bank or upper-RAM chip-select. In any other state the write raises no chip-select and no ram_we.
- R9: During a read of a switch address, sw_doe is high and sw_dout is 0x00.
- R10: At most one chip-select is high at a time. None is high, and ram_we stays low, when bus_valid is low or the address is below 0xD000.
- R11: With a bank chip-select high, ram_addr is {bank, bus_addr[11:0]} (bank A = 0). With the upper chip-select high, ram_addr is bus_addr[12:0].
- R12: Switch state changes on the clock edge that ends the switch cycle. The very next access uses the new mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one bus cycle per edge when bus_valid is high |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A CPU cycle is in progress |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | 16 | CPU address |
| sw_dout | output | 8 | Data returned on switch reads (0x00) |
| sw_doe | output | 1 | Drive enable for sw_dout |
| cs_bank_a | output | 1 | Chip-select, first 4 KB bank |
| cs_bank_b | output | 1 | Chip-select, second 4 KB bank |
| cs_upper | output | 1 | Chip-select, fixed 8 KB upper RAM |
| cs_rom | output | 1 | Chip-select, motherboard ROM |
| ram_we | output | 1 | Write strobe to the selected card RAM |
| ram_addr | output | 13 | Address into the selected card RAM |

## Verification
The chip-selects, ram_we, ram_addr, sw_doe and sw_dout respond in the same cycle to the address presented, so they are due zero cycles after the stimulus. The switch state is due one clock edge after a switch cycle and shows up in the routing of the next access. The bench drives each cycle on the falling edge, compares every output 3 ns later against a behavioural model that still holds the pre-edge state, and advances the model only after the rising edge. This lets a probe access placed directly after a switch cycle observe the one-cycle update.

// File: rtl/bankram_pkg.sv
package bankram_pkg;

    // Write-enable state machine encoding
    typedef enum logic [1:0] {
        WE_OFF  = 2'd0,
        WE_HALF = 2'd1,
        WE_ON   = 2'd2
    } we_state_t;

    // Action selected by address bits 1:0 of a switch read
    typedef enum logic [1:0] {
        ACT_RAM_LOCK = 2'd0,
        ACT_ROM_ARM  = 2'd1,
        ACT_ROM_LOCK = 2'd2,
        ACT_RAM_ARM  = 2'd3
    } sw_act_t;

    // Destination of one bus cycle
    typedef enum logic [2:0] {
        RT_NONE   = 3'd0,
        RT_BANK_A = 3'd1,
        RT_BANK_B = 3'd2,
        RT_UPPER  = 3'd3,
        RT_ROM    = 3'd4
    } route_t;

    // Decoded switch command
    typedef struct packed {
        logic    hit;
        logic    is_read;
        logic    bank;
        sw_act_t act;
    } sw_cmd_t;

    function automatic we_state_t we_step(input we_state_t s);
        unique case (s)
            WE_OFF:  return WE_HALF;
            WE_HALF: return WE_ON;
            WE_ON:   return WE_ON;
            default: return WE_OFF;
        endcase
    endfunction

endpackage

// File: rtl/bankram_swdec.sv
module bankram_swdec
    import bankram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SLOT   = 0
) (
    input  logic              bus_valid,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output sw_cmd_t           cmd,
    output logic              sw_doe,
    output logic [DATA_W-1:0] sw_dout
);
    localparam int WIN_W = ADDR_W - 4;
    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(32'hC080 + 32'(SLOT) * 32'd16);
    localparam logic [WIN_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:4];

    logic in_win;
    logic unused_bit2;

    assign unused_bit2 = bus_addr[2];
    assign in_win      = bus_valid && (bus_addr[ADDR_W-1:4] == WIN_TAG);

    always_comb begin
        cmd.hit     = in_win;
        cmd.is_read = bus_rd;
        cmd.bank    = bus_addr[3];
        cmd.act     = sw_act_t'(bus_addr[1:0]);
    end

    assign sw_doe  = in_win && bus_rd;
    assign sw_dout = '0;

endmodule

// File: rtl/bankram_state.sv
module bankram_state
    import bankram_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sw_cmd_t cmd,
    output logic    rd_ram,
    output logic    bank,
    output logic    we_open
);
    we_state_t we_q, we_d;
    logic      rd_q, rd_d;
    logic      bk_q, bk_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q <= WE_ON;
            rd_q <= 1'b0;
            bk_q <= 1'b1;
        end else begin
            we_q <= we_d;
            rd_q <= rd_d;
            bk_q <= bk_d;
        end
    end

    // Next-state logic
    always_comb begin
        we_d = we_q;
        rd_d = rd_q;
        bk_d = bk_q;
        if (cmd.hit) begin
            if (!cmd.is_read) begin
                we_d = WE_OFF;
            end else begin
                bk_d = cmd.bank;
                unique case (cmd.act)
                    ACT_RAM_LOCK: begin rd_d = 1'b1; we_d = WE_OFF;        end
                    ACT_ROM_ARM:  begin rd_d = 1'b0; we_d = we_step(we_q); end
                    ACT_ROM_LOCK: begin rd_d = 1'b0; we_d = WE_OFF;        end
                    ACT_RAM_ARM:  begin rd_d = 1'b1; we_d = we_step(we_q); end
                    default:      begin rd_d = rd_q; we_d = we_q;          end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        rd_ram  = rd_q;
        bank    = bk_q;
        we_open = (we_q == WE_ON);
    end

    logic arming_rd;
    assign arming_rd = cmd.hit && cmd.is_read && cmd.act[0];

    assert_wr_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.hit && !cmd.is_read) |=> (we_q == WE_OFF && $stable(bk_q) && $stable(rd_q)));

    assert_bank_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.hit && cmd.is_read) |=> (bk_q == $past(cmd.bank)));

    assert_arm_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arming_rd && we_q != WE_OFF) |=> (we_q == WE_ON));

    assert_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.hit && cmd.is_read && !cmd.act[0]) |=> (we_q == WE_OFF && rd_q == !$past(cmd.act[1])));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd.hit |=> ($stable(we_q) && $stable(bk_q) && $stable(rd_q)));

endmodule

// File: rtl/bankram_steer.sv
module bankram_steer
    import bankram_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BANK_AW = 12,
    parameter int UPPER_AW = 13,
    parameter int RAM_AW  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              rd_ram,
    input  logic              bank,
    input  logic              we_open,
    output logic              cs_bank_a,
    output logic              cs_bank_b,
    output logic              cs_upper,
    output logic              cs_rom,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr
);
    logic [3:0] page16;
    logic       in_low, in_high;
    route_t     route;

    assign page16  = bus_addr[ADDR_W-1 -: 4];
    assign in_low  = bus_valid && (page16 == 4'hD);
    assign in_high = bus_valid && (page16 >= 4'hE);

    // Route selection
    always_comb begin
        route = RT_NONE;
        if (in_low || in_high) begin
            if (bus_rd) begin
                if (!rd_ram)     route = RT_ROM;
                else if (in_high) route = RT_UPPER;
                else             route = bank ? RT_BANK_B : RT_BANK_A;
            end else if (we_open) begin
                if (in_high)     route = RT_UPPER;
                else             route = bank ? RT_BANK_B : RT_BANK_A;
            end
        end
    end

    // Output decode
    always_comb begin
        cs_bank_a = 1'b0;
        cs_bank_b = 1'b0;
        cs_upper  = 1'b0;
        cs_rom    = 1'b0;
        ram_addr  = '0;
        unique case (route)
            RT_BANK_A: begin cs_bank_a = 1'b1; ram_addr = RAM_AW'({1'b0, bus_addr[BANK_AW-1:0]}); end
            RT_BANK_B: begin cs_bank_b = 1'b1; ram_addr = RAM_AW'({1'b1, bus_addr[BANK_AW-1:0]}); end
            RT_UPPER:  begin cs_upper  = 1'b1; ram_addr = RAM_AW'(bus_addr[UPPER_AW-1:0]);        end
            RT_ROM:    begin cs_rom    = 1'b1; end
            default:   begin end
        endcase
        ram_we = !bus_rd && (route != RT_NONE);
    end

    logic any_cs;
    assign any_cs = cs_bank_a | cs_bank_b | cs_upper | cs_rom;

    assert_cs_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cs_bank_a, cs_bank_b, cs_upper, cs_rom}));

    assert_cs_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid || bus_addr[ADDR_W-1 -: 4] < 4'hD) |-> (!any_cs && !ram_we));

    assert_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_rd && !we_open) |-> (!any_cs && !ram_we));

    assert_rom_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_rd && !rd_ram && bus_addr[ADDR_W-1 -: 4] >= 4'hD) |-> cs_rom);

    assert_upper_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_upper |-> (ram_addr == bus_addr[UPPER_AW-1:0]));

endmodule

// File: rtl/bankram_ctrl.sv
module bankram_ctrl
    import bankram_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int SLOT     = 0,
    parameter int BANK_AW  = 12,
    parameter int UPPER_AW = 13,
    localparam int RAM_AW  = (BANK_AW + 1 > UPPER_AW) ? BANK_AW + 1 : UPPER_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] sw_dout,
    output logic              sw_doe,
    output logic              cs_bank_a,
    output logic              cs_bank_b,
    output logic              cs_upper,
    output logic              cs_rom,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr
);
    sw_cmd_t cmd;
    logic    rd_ram, bank, we_open;

    bankram_swdec #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SLOT   (SLOT)
    ) u_swdec (
        .bus_valid (bus_valid),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .cmd       (cmd),
        .sw_doe    (sw_doe),
        .sw_dout   (sw_dout)
    );

    bankram_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .rd_ram  (rd_ram),
        .bank    (bank),
        .we_open (we_open)
    );

    bankram_steer #(
        .ADDR_W   (ADDR_W),
        .BANK_AW  (BANK_AW),
        .UPPER_AW (UPPER_AW),
        .RAM_AW   (RAM_AW)
    ) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .rd_ram    (rd_ram),
        .bank      (bank),
        .we_open   (we_open),
        .cs_bank_a (cs_bank_a),
        .cs_bank_b (cs_bank_b),
        .cs_upper  (cs_upper),
        .cs_rom    (cs_rom),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr)
    );

    assert_doe_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_doe |-> (bus_valid && bus_rd && sw_dout == '0 && !cs_rom && !ram_we));

endmodule

// File: tb/bankram_ctrl_bench.sv
module bankram_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_rd = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  sw_dout;
    logic        sw_doe;
    logic        cs_bank_a, cs_bank_b, cs_upper, cs_rom, ram_we;
    logic [12:0] ram_addr;

    always #4 clk = ~clk;   // 125 MHz

    bankram_ctrl u_bankram_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .sw_dout   (sw_dout),
        .sw_doe    (sw_doe),
        .cs_bank_a (cs_bank_a),
        .cs_bank_b (cs_bank_b),
        .cs_upper  (cs_upper),
        .cs_rom    (cs_rom),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr)
    );

    // Behavioural reference state
    int m_rd_ram;   // 1 = RAM reads
    int m_we;       // 0 off, 1 half, 2 on
    int m_bank;     // 0 = A, 1 = B

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (addr %h rd %0d)",
                     req, what, act, exp, bus_addr, bus_rd);
        end
    endtask

    task automatic compare_outputs(input string state_req);
        int  e_a, e_b, e_u, e_r, e_we, e_oe, e_ad;
        bit  in_rng, in_win, route_ok;
        string rq;
        in_rng = bus_valid && (bus_addr >= 16'hD000);
        in_win = bus_valid && (bus_addr[15:4] == 12'hC08);
        route_ok = bus_rd ? (m_rd_ram == 1) : (m_we == 2);
        e_a  = (in_rng && route_ok && bus_addr < 16'hE000 && m_bank == 0) ? 1 : 0;
        e_b  = (in_rng && route_ok && bus_addr < 16'hE000 && m_bank == 1) ? 1 : 0;
        e_u  = (in_rng && route_ok && bus_addr >= 16'hE000) ? 1 : 0;
        e_r  = (in_rng && bus_rd && m_rd_ram == 0) ? 1 : 0;
        e_we = (in_rng && !bus_rd && m_we == 2) ? 1 : 0;
        e_oe = (in_win && bus_rd) ? 1 : 0;
        rq = !in_rng ? "R10" : (bus_rd ? "R7" : "R8");
        if (state_req != "") rq = {rq, "/", state_req};
        chk(cs_bank_a == e_a, rq, "cs_bank_a", int'(cs_bank_a), e_a);
        chk(cs_bank_b == e_b, rq, "cs_bank_b", int'(cs_bank_b), e_b);
        chk(cs_upper  == e_u, rq, "cs_upper",  int'(cs_upper),  e_u);
        chk(cs_rom    == e_r, rq, "cs_rom",    int'(cs_rom),    e_r);
        chk(ram_we    == e_we, rq, "ram_we",   int'(ram_we),    e_we);
        chk(sw_doe    == e_oe, "R1", "sw_doe", int'(sw_doe),    e_oe);
        if (e_oe == 1)
            chk(sw_dout == 8'h00, "R9", "sw_dout", int'(sw_dout), 0);
        if (e_a == 1 || e_b == 1) begin
            e_ad = (m_bank << 12) | int'(bus_addr[11:0]);
            chk(ram_addr == 13'(e_ad), "R11", "ram_addr", int'(ram_addr), e_ad);
        end else if (e_u == 1) begin
            e_ad = int'(bus_addr[12:0]);
            chk(ram_addr == 13'(e_ad), "R11", "ram_addr", int'(ram_addr), e_ad);
        end
    endtask

    // One bus cycle: drive at falling edge, compare before rising edge, then advance model
    task automatic cyc(input bit v, input bit rd, input logic [15:0] a, input string req);
        @(negedge clk);
        bus_valid = v;
        bus_rd    = rd;
        bus_addr  = a;
        #3;
        compare_outputs(req);
        @(posedge clk);
        if (v && a[15:4] == 12'hC08) begin
            if (!rd) m_we = 0;
            else begin
                m_bank = int'(a[3]);
                case (a[1:0])
                    2'd0: begin m_rd_ram = 1; m_we = 0; end
                    2'd1: begin m_rd_ram = 0; m_we = (m_we < 2) ? m_we + 1 : 2; end
                    2'd2: begin m_rd_ram = 0; m_we = 0; end
                    default: begin m_rd_ram = 1; m_we = (m_we < 2) ? m_we + 1 : 2; end
                endcase
            end
        end
    endtask

    // Probe pattern covering both windows for reads and writes
    task automatic probes(input string req);
        cyc(1, 1, 16'hD000, req);
        cyc(1, 1, 16'hDABC, req);
        cyc(1, 1, 16'hE123, req);
        cyc(1, 1, 16'hFFFF, req);
        cyc(1, 0, 16'hD456, req);
        cyc(1, 0, 16'hF00D, req);
        cyc(1, 1, 16'hCFFF, req);
        cyc(0, 1, 16'hD000, req);
    endtask

    initial begin
        m_rd_ram = 0; m_we = 2; m_bank = 1;
        repeat (3) @(negedge clk);
        bus_valid = 1'b1; bus_rd = 1'b1; bus_addr = 16'hD000;
        #3;
        // R10: reset holds all selects low even with a valid-looking cycle? Only state is reset; outputs follow state.
        chk(cs_rom == 1'b1, "R2", "cs_rom in reset", int'(cs_rom), 1);
        chk(cs_bank_a == 1'b0 && cs_bank_b == 1'b0, "R2", "bank cs in reset",
            int'({cs_bank_a, cs_bank_b}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        bus_valid = 1'b0;

        // R2: reset mapping (ROM reads, writes open into bank B)
        probes("R2");
        cyc(1, 1, 16'h1234, "R10");
        cyc(1, 0, 16'hC000, "R10");

        // R4: action 0, bank A -> RAM reads, writes locked; R12 probe right after
        cyc(1, 1, 16'hC080, "R4");
        probes("R12");
        // R5: two arming reads with bank B, RAM reads; a write in between the arming is discarded
        cyc(1, 1, 16'hC08B, "R5");
        cyc(1, 0, 16'hD100, "R5");
        cyc(1, 1, 16'hC08B, "R5");
        probes("R5");
        // R5: saturation plus ROM read arming, R3: bank A via bit 3 = 0
        cyc(1, 1, 16'hC081, "R5");
        cyc(1, 1, 16'hC081, "R5");
        cyc(1, 1, 16'hC081, "R5");
        probes("R3");
        // R6: switch write clears write state, keeps read source and bank
        cyc(1, 1, 16'hC083, "R6");
        cyc(1, 1, 16'hC083, "R6");
        cyc(1, 0, 16'hC08B, "R6");
        probes("R6");
        // R6: write between arming reads restarts the count
        cyc(1, 1, 16'hC08F, "R6");
        cyc(1, 0, 16'hC084, "R6");
        cyc(1, 1, 16'hC08F, "R6");
        probes("R6");
        cyc(1, 1, 16'hC08F, "R5");
        probes("R5");
        // R1: another slot's window has no effect
        cyc(1, 1, 16'hC090, "R1");
        cyc(1, 1, 16'hC0F2, "R1");
        cyc(1, 0, 16'hC090, "R1");
        probes("R1");
        // R4: action 2 locks and selects ROM
        cyc(1, 1, 16'hC08A, "R4");
        probes("R4");
        // R3/R4/R5/R9: every switch address in turn
        for (int i = 0; i < 16; i++) begin
            cyc(1, 1, 16'hC080 + 16'(i), "R9");
            probes("R3");
        end
        for (int i = 0; i < 16; i++) begin
            cyc(1, 1, 16'hC083 - 16'(i % 4), "R4");
            cyc(1, 1, 16'hC08B, "R5");
            cyc(1, 0, 16'hE000 + 16'(i * 16'h111), "R8");
            cyc(1, 1, 16'hDF00 + 16'(i), "R7");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        done = 1;
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule